// File: doc/BRIEF.md
# Trap Entry Sequencer

This block is the multi-cycle controller that starts a service routine on a 16-bit byte-addressed processor. An exception strobe is accepted whenever the sequencer is idle. A pending interrupt is accepted only at an instruction boundary. Both kinds of event then run the same steps. The privilege bit of the status word is cleared. R6 is moved onto the supervisor stack when the machine was in user mode. The old status word and the return PC are pushed. The handler address is then read from a vector table and handed back as the new PC.

The block owns the two saved stack pointers and exposes their values. The caller supplies the live status word, PC and R6, and writes back the new PC, status word and R6 in the cycle the block pulses `done`. Memory is reached through a simple word port: the block holds each request steady until the port signals ready.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the sequencer is idle with `busy`, `mem_req` and `done` low, the saved supervisor stack pointer is 0x3000 and the saved user stack pointer is 0xFE00.
- R2: The status word returned with `done` equals the status word captured at acceptance with bit 15 (1 = user, 0 = supervisor) forced to 0.
- R3: If bit 15 of the captured status word is 1, the captured R6 is stored as the user stack pointer and pushes use the saved supervisor stack pointer. If bit 15 is 0, pushes use the captured R6 and the user stack pointer is left unchanged.
- R4: Each push first lowers the stack pointer by 2 and then writes one word there. The first write carries the old status word at SP-2, the second carries the return PC at SP-4, and the returned R6 is SP-4.
- R5: After the pushes, one read is made at 0x0200 + 2*vector, and the word read is returned as the new PC. For the timer vector 0x01 the read address is 0x0202.
- R6: The pushed return PC is the captured PC minus 2 for an exception and the captured PC unchanged for an interrupt.
- R7: When an exception and an interrupt are requested in the same idle cycle, the exception is taken (`exc_ack` high, `int_ack` low). The still-pending interrupt is taken on the first idle cycle after `done`.
- R8: An interrupt request is not accepted while `boundary` is low. An exception request is accepted whenever the sequencer is idle.
- R9: While `mem_req` is high and `mem_ready` is low, the address, write data and write enable hold their values.
- R10: `done` is high for exactly one cycle per accepted event. Requests raised while `busy` is high start no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request strobe |
| exc_vec | input | 8 | Exception vector |
| int_req | input | 1 | Pending interrupt (level) |
| int_vec | input | 8 | Interrupt vector |
| boundary | input | 1 | High at an instruction boundary |
| psr_in | input | 16 | Current status word |
| pc_in | input | 16 | Current PC |
| r6_in | input | 16 | Current R6 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address (word aligned) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Memory step completes at this edge |
| busy | output | 1 | Sequence in progress |
| exc_ack | output | 1 | Exception accepted at this edge |
| int_ack | output | 1 | Interrupt accepted at this edge |
| done | output | 1 | New PC, status word and R6 are valid |
| new_pc | output | 16 | Handler address |
| new_psr | output | 16 | Status word with privilege cleared |
| new_r6 | output | 16 | Supervisor stack pointer after the pushes |
| usp_o | output | 16 | Saved user stack pointer |
| ssp_o | output | 16 | Saved supervisor stack pointer |

## Verification
An exception strobe and a pending interrupt at a boundary can fall in the same idle cycle, and only one of them may start the sequence. The bench raises both together on the same edge with different vectors. It expects the exception acknowledge alone, then a full exception entry with the decremented PC and the exception vector's table slot. It then expects a second, separate interrupt entry that starts on the idle cycle following `done`, with the undecremented PC and the interrupt's slot. Each push address, pushed word and returned value is compared against bench arithmetic. This runs while memory latency varies at random.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int WORD_W_DEF = 16;
  localparam int VEC_W_DEF  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PSR,
    ST_PUSH_PC,
    ST_FETCH,
    ST_LOAD
  } seq_state_t;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int VEC_W = 8
) (
  input  logic             idle,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic             int_req,
  input  logic [VEC_W-1:0] int_vec,
  input  logic             boundary,
  output logic             take,
  output logic             take_exc,
  output logic [VEC_W-1:0] take_vec,
  output logic             exc_ack,
  output logic             int_ack
);
  logic int_ok;

  // an interrupt only counts at an instruction boundary, and only if no exception competes
  assign int_ok   = int_req && boundary && !exc_req;
  assign exc_ack  = idle && exc_req;
  assign int_ack  = idle && int_ok;
  assign take     = exc_ack || int_ack;
  assign take_exc = exc_req;
  assign take_vec = exc_req ? exc_vec : int_vec;
endmodule

// File: rtl/trap_stack_sel.sv
module trap_stack_sel #(
  parameter int          W        = 16,
  parameter logic [15:0] SSP_INIT = 16'h3000,
  parameter logic [15:0] USP_INIT = 16'hFE00,
  parameter int          STEP     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         user_mode,
  input  logic [W-1:0] r6_in,
  input  logic         step_dec,
  output logic [W-1:0] sp_q,
  output logic [W-1:0] push_addr,
  output logic [W-1:0] usp_q,
  output logic [W-1:0] ssp_q
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  function automatic logic [W-1:0] pre_dec(input logic [W-1:0] sp);
    return sp - STEP_V;
  endfunction

  assign push_addr = pre_dec(sp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= W'(SSP_INIT);
      usp_q <= W'(USP_INIT);
      ssp_q <= W'(SSP_INIT);
    end else if (load) begin
      if (user_mode) begin
        usp_q <= r6_in;
        sp_q  <= ssp_q;
      end else begin
        sp_q  <= r6_in;
      end
    end else if (step_dec) begin
      sp_q <= pre_dec(sp_q);
    end
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_entry_pkg::*;
#(
  parameter int          W          = 16,
  parameter int          VEC_W      = 8,
  parameter logic [15:0] TABLE_BASE = 16'h0200,
  parameter int          PC_STEP    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             take_exc,
  input  logic [VEC_W-1:0] take_vec,
  input  logic [W-1:0]     psr_in,
  input  logic [W-1:0]     pc_in,
  input  logic [W-1:0]     push_addr,
  input  logic [W-1:0]     sp_q,
  input  logic [W-1:0]     mem_rdata,
  input  logic             mem_ready,
  output logic             busy,
  output logic             idle,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  output logic             step_dec,
  output logic             done,
  output logic [W-1:0]     new_pc,
  output logic [W-1:0]     new_psr,
  output logic [W-1:0]     new_r6
);
  localparam int PRIV_BIT = W - 1;
  localparam int PAD_W    = W - VEC_W - 1;

  seq_state_t       state_q, state_d;
  logic [W-1:0]     old_psr_q, ret_pc_q, handler_q;
  logic [VEC_W-1:0] vec_q;
  logic             step_ok;

  function automatic logic [W-1:0] slot_addr(input logic [VEC_W-1:0] v);
    return W'(TABLE_BASE) + {{PAD_W{1'b0}}, v, 1'b0};
  endfunction

  function automatic logic [W-1:0] ret_pc(input logic [W-1:0] pc, input logic is_exc);
    return is_exc ? pc - W'(PC_STEP) : pc;
  endfunction

  function automatic logic [W-1:0] drop_priv(input logic [W-1:0] psr);
    logic [W-1:0] r;
    r = psr;
    r[PRIV_BIT] = 1'b0;
    return r;
  endfunction

  assign idle     = (state_q == ST_IDLE);
  assign busy     = !idle;
  assign mem_req  = (state_q == ST_PUSH_PSR) || (state_q == ST_PUSH_PC) || (state_q == ST_FETCH);
  assign mem_we   = (state_q == ST_PUSH_PSR) || (state_q == ST_PUSH_PC);
  assign step_ok  = mem_req && mem_ready;
  assign step_dec = mem_we && mem_ready;
  assign done     = (state_q == ST_LOAD);
  assign new_pc   = handler_q;
  assign new_psr  = drop_priv(old_psr_q);
  assign new_r6   = sp_q;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_PUSH_PSR: begin mem_addr = push_addr; mem_wdata = old_psr_q; end
      ST_PUSH_PC:  begin mem_addr = push_addr; mem_wdata = ret_pc_q;  end
      ST_FETCH:    mem_addr = slot_addr(vec_q);
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (take)    state_d = ST_PUSH_PSR;
      ST_PUSH_PSR: if (step_ok) state_d = ST_PUSH_PC;
      ST_PUSH_PC:  if (step_ok) state_d = ST_FETCH;
      ST_FETCH:    if (step_ok) state_d = ST_LOAD;
      ST_LOAD:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      old_psr_q <= '0;
      ret_pc_q  <= '0;
      handler_q <= '0;
      vec_q     <= '0;
    end else begin
      state_q <= state_d;
      if (idle && take) begin
        old_psr_q <= psr_in;
        ret_pc_q  <= ret_pc(pc_in, take_exc);
        vec_q     <= take_vec;
      end
      if (state_q == ST_FETCH && mem_ready) handler_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int          W          = WORD_W_DEF,
  parameter int          VEC_W      = VEC_W_DEF,
  parameter logic [15:0] TABLE_BASE = 16'h0200,
  parameter logic [15:0] SSP_INIT   = 16'h3000,
  parameter logic [15:0] USP_INIT   = 16'hFE00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic             int_req,
  input  logic [VEC_W-1:0] int_vec,
  input  logic             boundary,
  input  logic [W-1:0]     psr_in,
  input  logic [W-1:0]     pc_in,
  input  logic [W-1:0]     r6_in,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata,
  input  logic             mem_ready,
  output logic             busy,
  output logic             exc_ack,
  output logic             int_ack,
  output logic             done,
  output logic [W-1:0]     new_pc,
  output logic [W-1:0]     new_psr,
  output logic [W-1:0]     new_r6,
  output logic [W-1:0]     usp_o,
  output logic [W-1:0]     ssp_o
);
  localparam int WORD_BYTES = W / 8;

  // named internal events, observed by the checker
  logic             accept_evt;
  logic             push_evt;
  logic             idle;
  logic             take_exc;
  logic [VEC_W-1:0] take_vec;
  logic [W-1:0]     sp_q;
  logic [W-1:0]     push_addr;

  trap_arbiter #(.VEC_W(VEC_W)) u_arb (
    .idle     (idle),
    .exc_req  (exc_req),
    .exc_vec  (exc_vec),
    .int_req  (int_req),
    .int_vec  (int_vec),
    .boundary (boundary),
    .take     (accept_evt),
    .take_exc (take_exc),
    .take_vec (take_vec),
    .exc_ack  (exc_ack),
    .int_ack  (int_ack)
  );

  trap_stack_sel #(
    .W(W), .SSP_INIT(SSP_INIT), .USP_INIT(USP_INIT), .STEP(WORD_BYTES)
  ) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_evt),
    .user_mode (psr_in[W-1]),
    .r6_in     (r6_in),
    .step_dec  (push_evt),
    .sp_q      (sp_q),
    .push_addr (push_addr),
    .usp_q     (usp_o),
    .ssp_q     (ssp_o)
  );

  trap_seq #(
    .W(W), .VEC_W(VEC_W), .TABLE_BASE(TABLE_BASE), .PC_STEP(WORD_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (accept_evt),
    .take_exc  (take_exc),
    .take_vec  (take_vec),
    .psr_in    (psr_in),
    .pc_in     (pc_in),
    .push_addr (push_addr),
    .sp_q      (sp_q),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .busy      (busy),
    .idle      (idle),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .step_dec  (push_evt),
    .done      (done),
    .new_pc    (new_pc),
    .new_psr   (new_psr),
    .new_r6    (new_r6)
  );
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_req,
  input logic         mem_ready,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         busy,
  input logic         done,
  input logic         exc_ack,
  input logic         int_ack,
  input logic         boundary,
  input logic         accept_evt,
  input logic [W-1:0] new_psr
);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept_evt);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  // R7
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ack |-> !int_ack);
  // R8
  int_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> boundary);
  // R2
  priv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !new_psr[W-1]);
  // R4
  push_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_addr[0]);
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .busy       (busy),
  .done       (done),
  .exc_ack    (exc_ack),
  .int_ack    (int_ack),
  .boundary   (boundary),
  .accept_evt (accept_evt),
  .new_psr    (new_psr)
);

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        exc_req = 0, int_req = 0, boundary = 0;
  logic [7:0]  exc_vec = 0, int_vec = 0;
  logic [15:0] psr_in = 0, pc_in = 0, r6_in = 0;
  logic        mem_req, mem_we, mem_ready = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        busy, exc_ack, int_ack, done;
  logic [15:0] new_pc, new_psr, new_r6, usp_o, ssp_o;

  int checks = 0, errors = 0;
  logic [15:0] usp_model = 16'hFE00;
  logic [15:0] wa [0:3], wd [0:3], ra;
  int          wn = 0, rn = 0, lat = 0;
  logic        hold_bad = 0, prev_wait = 0;
  logic [15:0] prev_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq u_trap_entry_seq (.*);

  function automatic logic [15:0] table_word(input logic [15:0] a);
    return (a ^ 16'h5A5A) & 16'hFFFE;
  endfunction
  function automatic logic [15:0] slot_of(input logic [7:0] v);
    return 16'h0200 + 16'(v) * 16'd2;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: random latency, logs every completed step
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 0;
      lat = $urandom_range(0, 3);
      prev_wait = 0;
    end else if (mem_req) begin
      if (prev_wait && mem_addr != prev_addr) hold_bad = 1;
      prev_wait = 1;
      prev_addr = mem_addr;
      if (lat == 0) begin
        mem_ready = 1;
        if (mem_we) begin
          if (wn < 4) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
          wn++;
        end else begin
          ra = mem_addr; rn++;
          mem_rdata = table_word(mem_addr);
        end
      end else lat--;
    end
  end

  task automatic expect_entry(input bit is_exc, input logic [15:0] psr, input logic [15:0] pc,
                              input logic [15:0] r6, input logic [7:0] v);
    logic [15:0] sp, rpc;
    int n = 0;
    sp  = psr[15] ? 16'h3000 : r6;
    rpc = is_exc ? pc - 16'd2 : pc;
    if (psr[15]) usp_model = r6;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(done, "R10 done seen", 16'(done), 16'd1);
    chk(wn == 2, "R4 write count", 16'(wn), 16'd2);
    chk(wa[0] == sp - 16'd2 && wd[0] == psr, "R4 first push psr", wd[0], psr);
    chk(wa[1] == sp - 16'd4, "R4/R3 second push addr", wa[1], sp - 16'd4);
    chk(wd[1] == rpc, "R6 pushed pc", wd[1], rpc);
    chk(rn == 1 && ra == slot_of(v), "R5 table read addr", ra, slot_of(v));
    chk(new_pc == table_word(slot_of(v)), "R5 new pc", new_pc, table_word(slot_of(v)));
    chk(new_psr == {1'b0, psr[14:0]}, "R2 new psr", new_psr, {1'b0, psr[14:0]});
    chk(new_r6 == sp - 16'd4, "R4 new r6", new_r6, sp - 16'd4);
    chk(usp_o == usp_model && ssp_o == 16'h3000, "R3 saved sps", usp_o, usp_model);
    chk(!hold_bad, "R9 request held", 16'(hold_bad), 16'd0);
    @(negedge clk);
    chk(!done, "R10 done one cycle", 16'(done), 16'd0);
  endtask

  task automatic run_one(input bit is_exc, input logic [15:0] psr, input logic [15:0] pc,
                         input logic [15:0] r6, input logic [7:0] v);
    @(negedge clk);
    wn = 0; rn = 0;
    psr_in = psr; pc_in = pc; r6_in = r6;
    if (is_exc) begin exc_req = 1; exc_vec = v; end
    else begin int_req = 1; int_vec = v; boundary = 1; end
    #1;
    chk(is_exc ? exc_ack : int_ack, "R8 accepted when idle", 16'(is_exc ? exc_ack : int_ack), 16'd1);
    @(negedge clk);
    exc_req = 0; int_req = 0;
    expect_entry(is_exc, psr, pc, r6, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req && !done, "R1 idle after reset", {busy, mem_req, done}, 0);
    chk(ssp_o == 16'h3000, "R1 ssp reset", ssp_o, 16'h3000);
    chk(usp_o == 16'hFE00, "R1 usp reset", usp_o, 16'hFE00);

    // R5 timer vector from user mode, slot 0x0202
    run_one(0, 16'h8002, 16'h3010, 16'hFDF0, 8'h01);
    chk(ra == 16'h0202, "R5 timer slot", ra, 16'h0202);
    // R6 exception from supervisor mode, stack untouched
    run_one(1, 16'h0004, 16'h1208, 16'h2FF0, 8'h02);

    // R8 interrupt held off without boundary
    @(negedge clk);
    int_req = 1; int_vec = 8'h01; boundary = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!busy && !int_ack, "R8 no accept off boundary", {busy, int_ack}, 0);
    end
    int_req = 0;

    // R7 both together: exception first, interrupt after
    @(negedge clk);
    wn = 0; rn = 0;
    psr_in = 16'h8001; pc_in = 16'h3100; r6_in = 16'hFD00;
    exc_req = 1; exc_vec = 8'h03; int_req = 1; int_vec = 8'h01; boundary = 1;
    #1;
    chk(exc_ack && !int_ack, "R7 exception wins", {exc_ack, int_ack}, 16'd2);
    @(negedge clk);
    exc_req = 0;
    // R10 request during busy ignored
    exc_vec = 8'h44;
    exc_req = 1; @(negedge clk); exc_req = 0;
    expect_entry(1, 16'h8001, 16'h3100, 16'hFD00, 8'h03);
    #1;
    chk(int_ack, "R7 interrupt after exception", 16'(int_ack), 16'd1);
    wn = 0; rn = 0;
    psr_in = 16'h0001;
    @(negedge clk);
    int_req = 0;
    expect_entry(0, 16'h0001, 16'h3100, 16'hFD00, 8'h01);
    @(negedge clk);
    chk(!busy, "R10 no extra event", 16'(busy), 16'd0);

    // random mix
    for (int k = 0; k < 24; k++) begin
      logic [15:0] p, pc, r;
      p  = 16'($urandom());
      pc = 16'($urandom()) & 16'hFFFE;
      r  = (16'($urandom()) & 16'hFFFE) | 16'h0010;
      run_one(1'($urandom()), p, pc, r, 8'($urandom()));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule